// File: doc/BRIEF.md
# Tape File Record Reader

This block sits behind a tape FM bit decoder and turns its stream of recovered bits back into a file. It hunts bit by bit for the end of the leader: a run of zero bits followed by a byte of all ones. Once aligned, it reads the record count. The count is sent twice, and the reader treats a disagreement between the two copies as an error. It then reads the records. Every record arrives twice in a row. Each copy carries a zero sync stretch, an all-ones mark, a fixed number of data bytes and an 8-bit checksum.

A copy's data bytes are held in a staging buffer until its checksum byte has been compared. Only a copy that passes is released on the byte stream, as index/byte pairs on consecutive cycles. When the first copy passes, the second is read and dropped. When the first fails, the second is used. When both fail, the record is reported bad and the read stops with an error. There is no end-of-file marker: the read ends after the second copy of the last record, and `done` rises once the last byte has been released.

A host pulses `start` to begin a read and may pulse `abort` at any time to drop it.

Top module: `tape_rec_reader`

## Requirements
- R1: The leader ends only at eight consecutive 1 bits that directly follow at least MIN_ZEROS (default 8) consecutive 0 bits. A run of ones after fewer zeros, or fewer than eight ones, is not taken as the mark. Each record copy is found by the same hunt.
- R2: The two bytes after the leader mark are the record count. When they are equal, `cnt_valid` rises with `cnt_out` equal to that value, and both hold until the next `start` or `abort`.
- R3: If the two count bytes differ, `err` and `done` rise, `cnt_valid` stays low, and no record status or data is produced.
- R4: A count of zero ends the read at once: `done` rises with `err` low and no record output.
- R5: A copy passes when its checksum byte equals the low 8 bits of the sum of its REC_BYTES (default 64) data bytes.
- R6: If the first copy passes, `rec_done` pulses with `rec_ok`=1 and `rec_id` equal to the record number (from 0), and that copy's bytes are released. The second copy is read but has no effect at the ports.
- R7: If the first copy fails and the second passes, `rec_done` pulses with `rec_ok`=1 and the second copy's bytes are released.
- R8: If both copies fail, `rec_done` pulses with `rec_ok`=0 and no data, `err` rises, `done` follows, and no later record is reported.
- R9: Released data appears starting the cycle after the `rec_done` pulse, as `data_valid` on REC_BYTES consecutive cycles with `data_idx` counting 0 up to REC_BYTES-1.
- R10: `done` rises only after the second copy of the last record has been consumed and the last data byte has been released, with `busy` low at that point.
- R11: After reset, and in the cycle after an `abort` pulse, `busy`, `done`, `err`, `cnt_valid`, `rec_done` and `data_valid` are all low, and later bits have no effect until the next `start`.
- R12: Bytes are assembled most significant bit first, counted from the bit that follows the mark.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a read (acted on when idle) |
| abort | input | 1 | Drop the current read and return to idle |
| bit_valid | input | 1 | A decoded tape bit is present this cycle |
| bit_val | input | 1 | Value of the decoded bit |
| busy | output | 1 | A read is in progress |
| done | output | 1 | Read finished (held until next start/abort) |
| err | output | 1 | Read finished with a count mismatch or an unreadable record |
| cnt_valid | output | 1 | `cnt_out` holds an agreed record count |
| cnt_out | output | BYTE_W | Record count of the file |
| rec_done | output | 1 | One-cycle pulse: a record has been decided |
| rec_ok | output | 1 | With `rec_done`: 1 if a copy passed its checksum |
| rec_id | output | BYTE_W | Number of the record last decided |
| data_valid | output | 1 | `data_byte` and `data_idx` are valid |
| data_byte | output | BYTE_W | Released data byte |
| data_idx | output | clog2(REC_BYTES) | Position of the byte within its record |

## Verification
A framer that slips by a bit shows at the ports within the next copy as a failed checksum. This turns into a `rec_ok`=0 pulse, or corrupt bytes, inside about 600 bit strobes. A wrong copy or good-copy flag releases the wrong copy's bytes, or a duplicate `rec_done`, at the next checksum byte. A bad record counter shows as a `done` that comes early or late against the count. The bench sweeps every pass/fail pairing of copies over short files, bit by bit. It compares each released byte against the arithmetic pattern of the copy that should win, and checks the release cycle relative to `rec_done`.

// File: rtl/tfr_pkg.sv
package tfr_pkg;
   typedef enum logic [2:0] {
      S_IDLE,
      S_LEAD,
      S_CNT1,
      S_CNT2,
      S_HUNT,
      S_DATA,
      S_CSUM,
      S_FIN
   } rd_state_t;
endpackage

// File: rtl/tfr_bit_framer.sv
// Bit framer: hunts for a zero run followed by a full byte of ones,
// then assembles bytes MSB first from the following bits.
module tfr_bit_framer #(
   parameter int MIN_ZEROS = 8,
   parameter int BYTE_W    = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              hunt,
   input  logic              bit_valid,
   input  logic              bit_val,
   output logic              mark_hit,
   output logic              byte_valid,
   output logic [BYTE_W-1:0] byte_data
);
   localparam int ZW = $clog2(MIN_ZEROS + 1);
   localparam int OW = $clog2(BYTE_W + 1);
   localparam int CW = $clog2(BYTE_W);

   if (MIN_ZEROS < 1) begin : g_bad_zeros
      $error("MIN_ZEROS must be at least 1");
   end
   if (BYTE_W < 2 || (BYTE_W & (BYTE_W - 1)) != 0) begin : g_bad_width
      $error("BYTE_W must be a power of two");
   end

   logic [ZW-1:0]     zrun;
   logic [OW-1:0]     ones;
   logic [CW-1:0]     bcnt;
   logic [BYTE_W-1:0] sreg;

   assign mark_hit   = hunt & bit_valid & bit_val &
                       (ones == OW'(BYTE_W - 1)) & (zrun == ZW'(MIN_ZEROS));
   assign byte_valid = ~hunt & bit_valid & (bcnt == CW'(BYTE_W - 1));
   assign byte_data  = {sreg[BYTE_W-2:0], bit_val};

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         zrun <= '0;
         ones <= '0;
         bcnt <= '0;
         sreg <= '0;
      end else if (hunt) begin
         bcnt <= '0;
         if (bit_valid) begin
            if (mark_hit) begin
               zrun <= '0;
               ones <= '0;
            end else if (bit_val) begin
               if (ones != OW'(BYTE_W)) ones <= ones + 1'b1;
            end else begin
               if (ones != '0)                     zrun <= ZW'(1);
               else if (zrun != ZW'(MIN_ZEROS))    zrun <= zrun + 1'b1;
               ones <= '0;
            end
         end
      end else begin
         zrun <= '0;
         ones <= '0;
         if (bit_valid) begin
            sreg <= byte_data;
            bcnt <= bcnt + 1'b1;
         end
      end
   end
endmodule

// File: rtl/tfr_stage_buf.sv
// One-record staging store: one register per entry, combinational read.
module tfr_stage_buf #(
   parameter int DEPTH = 64,
   parameter int W     = 8
) (
   input  logic                     clk,
   input  logic                     wr_en,
   input  logic [$clog2(DEPTH)-1:0] wr_addr,
   input  logic [W-1:0]             wr_data,
   input  logic [$clog2(DEPTH)-1:0] rd_addr,
   output logic [W-1:0]             rd_data
);
   localparam int AW = $clog2(DEPTH);

   logic [DEPTH-1:0][W-1:0] rd_vec;

   for (genvar i = 0; i < DEPTH; i++) begin : g_entry
      logic [W-1:0] q;
      always_ff @(posedge clk) begin
         if (wr_en && wr_addr == AW'(i)) q <= wr_data;
      end
      assign rd_vec[i] = q;
   end

   assign rd_data = rd_vec[rd_addr];
endmodule

// File: rtl/tape_rec_reader.sv
module tape_rec_reader
   import tfr_pkg::*;
#(
   parameter int REC_BYTES  = 64,
   parameter int BYTE_W     = 8,
   parameter int MIN_ZEROS  = 8,
   parameter int SYNC_BYTES = 8
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         start,
   input  logic                         abort,
   input  logic                         bit_valid,
   input  logic                         bit_val,
   output logic                         busy,
   output logic                         done,
   output logic                         err,
   output logic                         cnt_valid,
   output logic [BYTE_W-1:0]            cnt_out,
   output logic                         rec_done,
   output logic                         rec_ok,
   output logic [BYTE_W-1:0]            rec_id,
   output logic                         data_valid,
   output logic [BYTE_W-1:0]            data_byte,
   output logic [$clog2(REC_BYTES)-1:0] data_idx
);
   localparam int IW = $clog2(REC_BYTES);

   // Release of a passed copy must finish before the next copy's first
   // data byte can arrive (sync + mark + one byte of bit strobes).
   if (REC_BYTES < 2 || REC_BYTES > BYTE_W * (SYNC_BYTES + 2)) begin : g_bad_depth
      $error("REC_BYTES out of range for the sync length");
   end
   if (MIN_ZEROS > BYTE_W * SYNC_BYTES) begin : g_bad_hunt
      $error("MIN_ZEROS longer than a record sync stretch");
   end

   rd_state_t         state;
   logic              fr_clr, hunt, mark_hit, byte_v;
   logic [BYTE_W-1:0] byte_d;
   logic [BYTE_W-1:0] cnt_a, rec_num, sum;
   logic [IW-1:0]     bidx, drain_ptr;
   logic              copy, good, drain_act, wr_en, pass, last_rec;
   logic [BYTE_W-1:0] rd_data;

   assign fr_clr   = abort | (state == S_IDLE);
   assign hunt     = (state == S_LEAD) | (state == S_HUNT);
   assign wr_en    = (state == S_DATA) & byte_v & ~(copy & good);
   assign pass     = (byte_d == sum);
   assign last_rec = (rec_num == cnt_out - 1'b1);
   assign busy     = (state != S_IDLE);

   tfr_bit_framer #(.MIN_ZEROS(MIN_ZEROS), .BYTE_W(BYTE_W)) u_framer (
      .clk(clk), .rst_n(rst_n), .clr(fr_clr), .hunt(hunt),
      .bit_valid(bit_valid), .bit_val(bit_val),
      .mark_hit(mark_hit), .byte_valid(byte_v), .byte_data(byte_d)
   );

   tfr_stage_buf #(.DEPTH(REC_BYTES), .W(BYTE_W)) u_stage (
      .clk(clk), .wr_en(wr_en), .wr_addr(bidx), .wr_data(byte_d),
      .rd_addr(drain_ptr), .rd_data(rd_data)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state      <= S_IDLE;
         done       <= 1'b0;
         err        <= 1'b0;
         cnt_valid  <= 1'b0;
         cnt_out    <= '0;
         cnt_a      <= '0;
         rec_done   <= 1'b0;
         rec_ok     <= 1'b0;
         rec_id     <= '0;
         rec_num    <= '0;
         copy       <= 1'b0;
         good       <= 1'b0;
         sum        <= '0;
         bidx       <= '0;
         drain_act  <= 1'b0;
         drain_ptr  <= '0;
         data_valid <= 1'b0;
         data_byte  <= '0;
         data_idx   <= '0;
      end else begin
         rec_done   <= 1'b0;
         data_valid <= 1'b0;
         if (drain_act) begin
            data_valid <= 1'b1;
            data_byte  <= rd_data;
            data_idx   <= drain_ptr;
            if (drain_ptr == IW'(REC_BYTES - 1)) drain_act <= 1'b0;
            else                                  drain_ptr <= drain_ptr + 1'b1;
         end
         if (abort) begin
            state      <= S_IDLE;
            drain_act  <= 1'b0;
            data_valid <= 1'b0;
            done       <= 1'b0;
            err        <= 1'b0;
            cnt_valid  <= 1'b0;
         end else begin
            unique case (state)
               S_IDLE: if (start) begin
                  state     <= S_LEAD;
                  done      <= 1'b0;
                  err       <= 1'b0;
                  cnt_valid <= 1'b0;
                  rec_num   <= '0;
                  copy      <= 1'b0;
                  good      <= 1'b0;
               end
               S_LEAD: if (mark_hit) state <= S_CNT1;
               S_CNT1: if (byte_v) begin
                  cnt_a <= byte_d;
                  state <= S_CNT2;
               end
               S_CNT2: if (byte_v) begin
                  if (byte_d != cnt_a) begin
                     err   <= 1'b1;
                     state <= S_FIN;
                  end else begin
                     cnt_out   <= byte_d;
                     cnt_valid <= 1'b1;
                     state     <= (byte_d == '0) ? S_FIN : S_HUNT;
                  end
               end
               S_HUNT: if (mark_hit) begin
                  state <= S_DATA;
                  bidx  <= '0;
                  sum   <= '0;
               end
               S_DATA: if (byte_v) begin
                  sum  <= sum + byte_d;
                  bidx <= bidx + 1'b1;
                  if (bidx == IW'(REC_BYTES - 1)) state <= S_CSUM;
               end
               S_CSUM: if (byte_v) begin
                  if (!copy) begin
                     copy  <= 1'b1;
                     state <= S_HUNT;
                     if (pass) begin
                        good      <= 1'b1;
                        rec_done  <= 1'b1;
                        rec_ok    <= 1'b1;
                        rec_id    <= rec_num;
                        drain_act <= 1'b1;
                        drain_ptr <= '0;
                     end
                  end else if (!good && !pass) begin
                     rec_done <= 1'b1;
                     rec_ok   <= 1'b0;
                     rec_id   <= rec_num;
                     err      <= 1'b1;
                     state    <= S_FIN;
                  end else begin
                     if (!good) begin
                        rec_done  <= 1'b1;
                        rec_ok    <= 1'b1;
                        rec_id    <= rec_num;
                        drain_act <= 1'b1;
                        drain_ptr <= '0;
                     end
                     copy <= 1'b0;
                     good <= 1'b0;
                     if (last_rec) state <= S_FIN;
                     else begin
                        rec_num <= rec_num + 1'b1;
                        state   <= S_HUNT;
                     end
                  end
               end
               S_FIN: if (!drain_act) begin
                  done  <= 1'b1;
                  state <= S_IDLE;
               end
               default: state <= S_IDLE;
            endcase
         end
      end
   end
endmodule

// File: rtl/tfr_checker.sv
module tfr_checker #(
   parameter int IDX_W  = 6,
   parameter int BYTE_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              abort,
   input logic              busy,
   input logic              done,
   input logic              err,
   input logic              cnt_valid,
   input logic [BYTE_W-1:0] cnt_out,
   input logic              rec_done,
   input logic              rec_ok,
   input logic              data_valid,
   input logic [IDX_W-1:0]  data_idx
);
   p_cnt_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_valid && $past(cnt_valid) |-> $stable(cnt_out));

   p_err_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
      err && !busy |-> done);

   p_recdone_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rec_done |-> busy);

   p_bad_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rec_done && !rec_ok |=> err && !data_valid);

   p_idx_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
      data_valid && $past(data_valid) |-> data_idx == IDX_W'($past(data_idx) + 1'b1));

   p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   p_abort_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      abort |=> !busy && !data_valid && !rec_done && !done);
endmodule

bind tape_rec_reader tfr_checker #(.IDX_W($clog2(REC_BYTES)), .BYTE_W(BYTE_W)) u_tfr_chk (
   .clk(clk), .rst_n(rst_n), .abort(abort), .busy(busy), .done(done),
   .err(err), .cnt_valid(cnt_valid), .cnt_out(cnt_out), .rec_done(rec_done),
   .rec_ok(rec_ok), .data_valid(data_valid), .data_idx(data_idx)
);

// File: tb/test_tape_rec_reader.sv
`timescale 1ns/1ps
module test_tape_rec_reader;
   localparam int NB = 64;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0, abort = 1'b0, bit_valid = 1'b0, bit_val = 1'b0;
   logic busy, done, err, cnt_valid, rec_done, rec_ok, data_valid;
   logic [7:0] cnt_out, rec_id, data_byte;
   logic [5:0] data_idx;

   always #4 clk = ~clk;

   tape_rec_reader i_tape_rec_reader (
      .clk(clk), .rst_n(rst_n), .start(start), .abort(abort),
      .bit_valid(bit_valid), .bit_val(bit_val), .busy(busy), .done(done),
      .err(err), .cnt_valid(cnt_valid), .cnt_out(cnt_out), .rec_done(rec_done),
      .rec_ok(rec_ok), .rec_id(rec_id), .data_valid(data_valid),
      .data_byte(data_byte), .data_idx(data_idx)
   );

   int checks = 0, fails = 0, gap = 0;
   logic [7:0] rx [8][NB];
   int rx_n [8];
   int rd_seen [8];
   logic rd_okv [8];
   int cur = 0, exp_idx = 0, order_err = 0, lat_err = 0, any_out = 0;
   logic last_rd = 1'b0;

   task automatic chk(input logic ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Output monitor
   always @(negedge clk) begin
      if (rst_n) begin
         if (data_valid) begin
            any_out++;
            if (data_idx == 6'd0 && !last_rd) lat_err++;
            if (int'(data_idx) != exp_idx) order_err++;
            exp_idx = int'(data_idx) + 1;
            rx[cur][data_idx] = data_byte;
            rx_n[cur]++;
         end
         if (rec_done) begin
            any_out++;
            cur = int'(rec_id) & 7;
            rd_seen[cur]++;
            rd_okv[cur] = rec_ok;
            exp_idx = 0;
         end
         last_rd = rec_done;
      end
   end

   task automatic clear_mon();
      for (int r = 0; r < 8; r++) begin
         rx_n[r] = 0;
         rd_seen[r] = 0;
         rd_okv[r] = 1'b0;
      end
      any_out = 0;
   endtask

   function automatic logic [7:0] pat(input int r, input int c, input int i);
      return 8'(r * 53 + i * 7 + c * 101 + 3);
   endfunction

   task automatic send_bit(input logic b);
      @(negedge clk);
      bit_valid = 1'b1;
      bit_val = b;
      repeat (gap) begin
         @(negedge clk);
         bit_valid = 1'b0;
      end
   endtask

   task automatic idle_bits();
      @(negedge clk);
      bit_valid = 1'b0;
   endtask

   task automatic send_byte(input logic [7:0] b);
      for (int k = 7; k >= 0; k--) send_bit(b[k]);
   endtask

   task automatic send_copy(input int r, input int c, input logic bad);
      logic [7:0] s;
      s = 8'd0;
      repeat (8) send_byte(8'h00);
      send_byte(8'hFF);
      for (int i = 0; i < NB; i++) begin
         send_byte(pat(r, c, i));
         s = s + pat(r, c, i);
      end
      send_byte(bad ? (s ^ 8'h5A) : s);
   endtask

   task automatic pulse_start();
      @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic wait_done();
      for (int k = 0; k < 400; k++) begin
         if (done) break;
         @(negedge clk);
      end
   endtask

   // code: two bits per record, bit0 = first copy bad, bit1 = second copy bad
   task automatic run_file(input int nrec, input int code, input int lead);
      int first_bad, mism, v;
      logic exp_err;
      clear_mon();
      pulse_start();
      repeat (lead) send_byte(8'h00);
      send_byte(8'hFF);
      send_byte(8'(nrec));
      send_byte(8'(nrec));
      for (int r = 0; r < nrec; r++) begin
         v = (code >> (2 * r)) & 3;
         send_copy(r, 0, v[0]);
         send_copy(r, 1, v[1]);
      end
      idle_bits();
      wait_done();
      first_bad = nrec;
      for (int r = nrec - 1; r >= 0; r--)
         if (((code >> (2 * r)) & 3) == 3) first_bad = r;
      exp_err = (first_bad < nrec);
      chk(done === 1'b1 && busy === 1'b0, "R10 done after last record", int'(done), 1);
      chk(err === exp_err, "R8 error flag", int'(err), int'(exp_err));
      // R12: MSB-first assembly makes count 1 read as 1, not 128
      chk(cnt_valid === 1'b1 && int'(cnt_out) == nrec, "R2 R12 record count", int'(cnt_out), nrec);
      for (int r = 0; r < nrec; r++) begin
         v = (code >> (2 * r)) & 3;
         if (r > first_bad) begin
            chk(rd_seen[r] == 0, "R8 no record after bad one", rd_seen[r], 0);
         end else if (v == 3) begin
            chk(rd_seen[r] == 1 && rd_okv[r] === 1'b0 && rx_n[r] == 0,
                "R8 both copies bad", rx_n[r], 0);
         end else begin
            chk(rd_seen[r] == 1 && rd_okv[r] === 1'b1, v[0] ? "R7 status" : "R6 status",
                rd_seen[r], 1);
            chk(rx_n[r] == NB, "R9 byte count", rx_n[r], NB);
            mism = 0;
            for (int i = 0; i < NB; i++)
               if (rx[r][i] !== pat(r, v[0] ? 1 : 0, i)) mism++;
            chk(mism == 0, v[0] ? "R7 R5 second copy data" : "R6 R5 first copy data", mism, 0);
         end
      end
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy && !done && !err && !cnt_valid && !data_valid && !rec_done,
          "R11 reset state", int'(busy), 0);

      // R1: false marks (ones after too few zeros; seven ones) then a real leader
      clear_mon();
      pulse_start();
      repeat (4) send_bit(1'b0);
      repeat (8) send_bit(1'b1);
      repeat (8) send_bit(1'b0);
      repeat (7) send_bit(1'b1);
      send_bit(1'b0);
      idle_bits();
      @(negedge clk);
      chk(busy === 1'b1 && cnt_valid === 1'b0, "R1 no false mark", int'(cnt_valid), 0);
      repeat (2) send_byte(8'h00);
      send_byte(8'hFF);
      send_byte(8'h01);
      send_byte(8'h01);
      send_copy(0, 0, 1'b0);
      send_copy(0, 1, 1'b0);
      idle_bits();
      wait_done();
      chk(done === 1'b1 && cnt_out == 8'd1 && rd_seen[0] == 1, "R1 real mark found",
          int'(cnt_out), 1);

      // R4: zero-record file
      clear_mon();
      pulse_start();
      repeat (2) send_byte(8'h00);
      send_byte(8'hFF);
      send_byte(8'h00);
      send_byte(8'h00);
      idle_bits();
      wait_done();
      chk(done && !err && cnt_valid && cnt_out == 8'd0 && any_out == 0,
          "R4 empty file", any_out, 0);

      // R3: count mismatch
      clear_mon();
      pulse_start();
      repeat (2) send_byte(8'h00);
      send_byte(8'hFF);
      send_byte(8'h03);
      send_byte(8'h04);
      send_copy(0, 0, 1'b0);
      idle_bits();
      wait_done();
      chk(done && err && !cnt_valid && any_out == 0, "R3 count mismatch", int'(err), 1);

      // R11: abort in the middle of a record
      clear_mon();
      pulse_start();
      repeat (2) send_byte(8'h00);
      send_byte(8'hFF);
      send_byte(8'h01);
      send_byte(8'h01);
      repeat (8) send_byte(8'h00);
      send_byte(8'hFF);
      for (int i = 0; i < 10; i++) send_byte(pat(0, 0, i));
      idle_bits();
      @(negedge clk);
      abort = 1'b1;
      @(negedge clk);
      abort = 1'b0;
      chk(!busy && !done && !err && !cnt_valid, "R11 abort to idle", int'(busy), 0);
      for (int i = 10; i < NB; i++) send_byte(pat(0, 0, i));
      send_byte(8'h00);
      send_copy(0, 1, 1'b0);
      idle_bits();
      repeat (80) @(negedge clk);
      chk(any_out == 0 && !busy && !done, "R11 bits ignored after abort", any_out, 0);

      // Sweeps: every copy pass/fail pairing, bits on every cycle
      gap = 0;
      for (int c = 0; c < 4; c++) run_file(1, c, 2);
      for (int c = 0; c < 16; c++) run_file(2, c, 2);
      // Three records with idle cycles between bit strobes
      gap = 2;
      run_file(3, 6'b00_01_10, 2);
      gap = 1;
      run_file(3, 6'b11_00_01, 1);
      run_file(3, 6'b00_00_00, 1);
      // Full-length leader
      gap = 0;
      run_file(1, 0, 768);

      chk(order_err == 0, "R9 index order", order_err, 0);
      chk(lat_err == 0, "R9 data starts after rec_done", lat_err, 0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule